// File: doc/BRIEF.md
# Calendar Register Write-Protect and Freeze Handshake

This block guards the loadable registers of a real-time calendar. Software reaches it over a simple 32-bit register bus on the bus clock. It loads time, date, prescaler and control values only after two things have happened. First, a two-byte unlock sequence must be written to a key register. Second, an init-mode request must have been acknowledged by the calendar's own clock domain. The acknowledge shows that the counters are frozen, and only then do loads take effect.

The request crosses into the RTC clock domain through a synchronizer. It comes back as a freeze acknowledge, which the bus domain synchronizes again. The RTC domain also produces a resynchronization event each time the shadow copies of time and date are refreshed. This happens every `RESYNC_PERIOD` RTC cycles while the calendar runs. Each event sets a sync flag that software may clear and then poll. An initialized flag tells boot software whether a calendar was already loaded, so that it can skip reconfiguration.

Register offsets: time 0x00, date 0x04, status 0x0C, prescaler 0x10, control 0x18, key 0x24.

Status bits:
- bit 7: init request, read/write
- bit 6: frozen acknowledge, read-only
- bit 5: sync flag, cleared by writing 0
- bit 4: initialized, read-only

Top module: `rtcwp_ctrl`

## Requirements
- R1: A key write whose low byte is 0x53 opens protection only when the write just before it to the key register had low byte 0xCA. A 0xCA write always arms the sequence, so 0xCA, 0xCA, 0x53 also opens protection.
- R2: Any other key write closes protection, including 0xFF, a wrong byte between the two keys, and 0x53 while not armed. The key register reads as zero.
- R3: Status bit 7 (init request) is written from write data bit 7 only while protection is open. While protection is closed, status writes leave it unchanged. It reads back on status bit 7.
- R4: After bit 7 is set, status bit 6 (frozen) and the `cal_freeze` output become 1 within 40 bus cycles. After bit 7 is cleared, both return to 0 within 40 bus cycles.
- R5: Writes to time, date, prescaler and control take effect only while protection is open and status bit 6 is 1. Otherwise they are ignored.
- R6: Loaded values are masked as follows: time 0x003F7F7F, date 0x00FFFF3F, prescaler 0x007F7FFF, control 0x000000FF. They read back masked and drive `cal_time`, `cal_date`, `cal_presc` and `cal_ctrl` from the cycle after the write.
- R7: Status bit 4 (initialized) becomes 1 when an accepted date load has a nonzero year field (bits 23:16) and 0 when that field is zero.
- R8: Status bit 5 (sync) is cleared by a status write with data bit 5 at 0, whatever the protection state. It is held at 0 while frozen. While running, it sets again within 150 bus cycles after a resync event.
- R9: After reset, time, date, control and status read 0 and the prescaler reads 0x007F00FF.
- R10: Read data appears on `bus_rdata` in the cycle after a read. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| rtc_clk | input | 1 | Calendar clock |
| rtc_rst | input | 1 | Synchronous active-high reset, calendar domain |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cal_freeze | output | 1 | Freeze to calendar core, calendar domain |
| cal_time | output | 32 | Loaded time value |
| cal_date | output | 32 | Loaded date value |
| cal_presc | output | 32 | Loaded prescaler value |
| cal_ctrl | output | 32 | Loaded control value |

## Verification
A wrong key state shows up one cycle after the next protected write. The load either appears on the `cal_*` outputs or fails to, and the bench compares those outputs against its model on every clock. A frozen flag that is stuck or slow shows up as a bounded poll of status bit 6 that times out. A lost or spurious resync event shows up the same way, through a bit-5 poll that times out or reads 0 where it should read 1. An initialized or init-request bit that disagrees with the model is reported on the very next status read.

// File: rtl/rtcwp_pkg.sv
package rtcwp_pkg;
  localparam int REG_W = 32;

  localparam logic [7:0] OFS_TIME   = 8'h00;
  localparam logic [7:0] OFS_DATE   = 8'h04;
  localparam logic [7:0] OFS_STAT   = 8'h0C;
  localparam logic [7:0] OFS_PRESC  = 8'h10;
  localparam logic [7:0] OFS_CTRL   = 8'h18;
  localparam logic [7:0] OFS_KEY    = 8'h24;

  localparam int ST_REQ    = 7;
  localparam int ST_FROZEN = 6;
  localparam int ST_SYNC   = 5;
  localparam int ST_LOADED = 4;

  localparam logic [7:0] KEY_ARM  = 8'hCA;
  localparam logic [7:0] KEY_OPEN = 8'h53;

  localparam logic [REG_W-1:0] MASK_TIME  = 32'h003F_7F7F;
  localparam logic [REG_W-1:0] MASK_DATE  = 32'h00FF_FF3F;
  localparam logic [REG_W-1:0] MASK_PRESC = 32'h007F_7FFF;
  localparam logic [REG_W-1:0] MASK_CTRL  = 32'h0000_00FF;
  localparam logic [REG_W-1:0] RST_PRESC  = 32'h007F_00FF;

  localparam int YEAR_LO = 16;
  localparam int YEAR_HI = 23;

  typedef enum logic [1:0] {KS_SHUT = 2'd0, KS_ARMED = 2'd1, KS_OPEN = 2'd2} key_state_t;
endpackage

// File: rtl/rtcwp_sync.sv
module rtcwp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rtcwp_keygate.sv
module rtcwp_keygate
  import rtcwp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  output logic       unlocked
);
  key_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= KS_SHUT;
    end else if (key_wr) begin
      if (state == KS_ARMED && key_byte == KEY_OPEN) state <= KS_OPEN;
      else if (key_byte == KEY_ARM)                  state <= KS_ARMED;
      else                                           state <= KS_SHUT;
    end
  end

  assign unlocked = (state == KS_OPEN);

  assert_open_after_second_key_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> ($past(key_wr) && $past(key_byte) == KEY_OPEN));

  assert_stray_key_closes_R2: assert property (@(posedge clk) disable iff (rst)
    (key_wr && key_byte != KEY_ARM && key_byte != KEY_OPEN) |=> !unlocked);
endmodule

// File: rtl/rtcwp_rtcside.sv
module rtcwp_rtcside #(
  parameter int SYNC_STAGES   = 2,
  parameter int RESYNC_PERIOD = 8
) (
  input  logic rtc_clk,
  input  logic rtc_rst,
  input  logic init_req,
  output logic freeze,
  output logic resync_tgl
);
  localparam int CNT_W = (RESYNC_PERIOD > 1) ? $clog2(RESYNC_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESYNC_PERIOD - 1);

  logic             req_s;
  logic [CNT_W-1:0] cnt;

  rtcwp_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(rtc_clk), .rst(rtc_rst), .d(init_req), .q(req_s)
  );

  always_ff @(posedge rtc_clk) begin
    if (rtc_rst) freeze <= 1'b0;
    else         freeze <= req_s;
  end

  always_ff @(posedge rtc_clk) begin
    if (rtc_rst) begin
      cnt        <= '0;
      resync_tgl <= 1'b0;
    end else if (freeze) begin
      cnt        <= '0;
    end else if (cnt == CNT_LAST) begin
      cnt        <= '0;
      resync_tgl <= ~resync_tgl;
    end else begin
      cnt        <= cnt + 1'b1;
    end
  end

  assert_no_resync_while_frozen_R8: assert property (@(posedge rtc_clk) disable iff (rtc_rst)
    freeze |=> $stable(resync_tgl));
endmodule

// File: rtl/rtcwp_ctrl.sv
module rtcwp_ctrl
  import rtcwp_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int RESYNC_PERIOD = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rtc_clk,
  input  logic              rtc_rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              cal_freeze,
  output logic [REG_W-1:0]  cal_time,
  output logic [REG_W-1:0]  cal_date,
  output logic [REG_W-1:0]  cal_presc,
  output logic [REG_W-1:0]  cal_ctrl
);
  logic wr_en, rd_en, unlocked, load_ok;
  logic hit_time, hit_date, hit_stat, hit_presc, hit_ctrl, hit_key;
  logic init_req_q, frozen_s, tgl_s, tgl_prev, sync_q, loaded_q, resync_evt;
  logic [REG_W-1:0] stat_word, rd_mux;
  logic freeze_rtc, tgl_rtc;

  assign wr_en     = bus_sel & bus_wr;
  assign rd_en     = bus_sel & ~bus_wr;
  assign hit_time  = (bus_addr == ADDR_W'(OFS_TIME));
  assign hit_date  = (bus_addr == ADDR_W'(OFS_DATE));
  assign hit_stat  = (bus_addr == ADDR_W'(OFS_STAT));
  assign hit_presc = (bus_addr == ADDR_W'(OFS_PRESC));
  assign hit_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_key   = (bus_addr == ADDR_W'(OFS_KEY));

  rtcwp_keygate u_key (
    .clk(clk), .rst(rst), .key_wr(wr_en & hit_key),
    .key_byte(bus_wdata[7:0]), .unlocked(unlocked)
  );

  rtcwp_rtcside #(.SYNC_STAGES(SYNC_STAGES), .RESYNC_PERIOD(RESYNC_PERIOD)) u_rtc (
    .rtc_clk(rtc_clk), .rtc_rst(rtc_rst), .init_req(init_req_q),
    .freeze(freeze_rtc), .resync_tgl(tgl_rtc)
  );
  assign cal_freeze = freeze_rtc;

  rtcwp_sync #(.STAGES(SYNC_STAGES)) u_frz_sync (
    .clk(clk), .rst(rst), .d(freeze_rtc), .q(frozen_s)
  );
  rtcwp_sync #(.STAGES(SYNC_STAGES)) u_tgl_sync (
    .clk(clk), .rst(rst), .d(tgl_rtc), .q(tgl_s)
  );

  assign load_ok    = unlocked & frozen_s;
  assign resync_evt = tgl_s ^ tgl_prev;

  // Protected calendar load registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cal_time  <= '0;
      cal_date  <= '0;
      cal_presc <= RST_PRESC;
      cal_ctrl  <= '0;
      loaded_q  <= 1'b0;
    end else if (wr_en && load_ok) begin
      if (hit_time)  cal_time  <= bus_wdata & MASK_TIME;
      if (hit_presc) cal_presc <= bus_wdata & MASK_PRESC;
      if (hit_ctrl)  cal_ctrl  <= bus_wdata & MASK_CTRL;
      if (hit_date) begin
        cal_date <= bus_wdata & MASK_DATE;
        loaded_q <= |bus_wdata[YEAR_HI:YEAR_LO];
      end
    end
  end

  // Init request and sync flag
  always_ff @(posedge clk) begin
    if (rst) begin
      init_req_q <= 1'b0;
      sync_q     <= 1'b0;
      tgl_prev   <= 1'b0;
    end else begin
      tgl_prev <= tgl_s;
      if (wr_en && hit_stat && unlocked) init_req_q <= bus_wdata[ST_REQ];
      if (frozen_s)                                    sync_q <= 1'b0;
      else if (resync_evt)                             sync_q <= 1'b1;
      else if (wr_en && hit_stat && !bus_wdata[ST_SYNC]) sync_q <= 1'b0;
    end
  end

  always_comb begin
    stat_word             = '0;
    stat_word[ST_REQ]     = init_req_q;
    stat_word[ST_FROZEN]  = frozen_s;
    stat_word[ST_SYNC]    = sync_q;
    stat_word[ST_LOADED]  = loaded_q;
    rd_mux = '0;
    if (hit_time)  rd_mux = cal_time;
    if (hit_date)  rd_mux = cal_date;
    if (hit_stat)  rd_mux = stat_word;
    if (hit_presc) rd_mux = cal_presc;
    if (hit_ctrl)  rd_mux = cal_ctrl;
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
    else            bus_rdata <= '0;
  end

  assert_locked_load_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_time && !unlocked) |=> $stable(cal_time));

  assert_unfrozen_load_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_date && !frozen_s) |=> $stable(cal_date));

  assert_req_guarded_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_stat && !unlocked) |=> $stable(init_req_q));

  assert_sync_clear_when_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    frozen_s |=> !sync_q);

  assert_loaded_follows_year_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_date && load_ok) |=> (loaded_q == ($past(bus_wdata[YEAR_HI:YEAR_LO]) != 8'h00)));
endmodule

// File: tb/tb_rtcwp_ctrl.sv
module tb_rtcwp_ctrl;
  logic clk = 1'b0, rtc_clk = 1'b0, rst = 1'b1, rtc_rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic cal_freeze;
  logic [31:0] cal_time, cal_date, cal_presc, cal_ctrl;

  always #2  clk = ~clk;
  always #10 rtc_clk = ~rtc_clk;

  rtcwp_ctrl dut (
    .clk(clk), .rst(rst), .rtc_clk(rtc_clk), .rtc_rst(rtc_rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cal_freeze(cal_freeze),
    .cal_time(cal_time), .cal_date(cal_date), .cal_presc(cal_presc), .cal_ctrl(cal_ctrl)
  );

  int checks = 0, failures = 0;
  bit cmp_on = 0, done = 0;

  // behavioural model
  int m_key = 0;            // 0 shut, 1 armed, 2 open
  bit m_frozen = 0, m_req = 0, m_loaded = 0;
  logic [31:0] m_time = 0, m_date = 0, m_presc = 32'h007F00FF, m_ctrl = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (cmp_on) begin
      check("R6 cal_time",  cal_time,  m_time);
      check("R6 cal_date",  cal_date,  m_date);
      check("R6 cal_presc", cal_presc, m_presc);
      check("R6 cal_ctrl",  cal_ctrl,  m_ctrl);
    end
  end

  task automatic model_write(logic [7:0] a, logic [31:0] d);
    case (a)
      8'h24: begin
        if (m_key == 1 && d[7:0] == 8'h53) m_key = 2;
        else if (d[7:0] == 8'hCA)          m_key = 1;
        else                               m_key = 0;
      end
      8'h00: if (m_key == 2 && m_frozen) m_time  = d & 32'h003F7F7F;
      8'h10: if (m_key == 2 && m_frozen) m_presc = d & 32'h007F7FFF;
      8'h18: if (m_key == 2 && m_frozen) m_ctrl  = d & 32'h000000FF;
      8'h04: if (m_key == 2 && m_frozen) begin
        m_date = d & 32'h00FFFF3F;
        m_loaded = (d[23:16] != 0);
      end
      8'h0C: if (m_key == 2) m_req = d[7];
      default: ;
    endcase
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 0;
  endtask

  // read status until bit b equals v, at most n reads
  task automatic poll(int b, bit v, int n, output bit ok);
    logic [31:0] s;
    ok = 0;
    for (int i = 0; i < n; i++) begin
      rd(8'h0C, s);
      if (s[b] == v) begin ok = 1; break; end
    end
  endtask

  task automatic check_stat(string req);
    logic [31:0] s;
    rd(8'h0C, s);
    check(req, s & 32'hFFFFFF9F, {24'h0, m_req, 2'b00, m_loaded, 4'h0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bit ok;
    repeat (20) @(posedge clk);
    @(negedge clk); rst = 0; rtc_rst = 0;
    cmp_on = 1;

    // R9 reset state
    rd(8'h0C, v); check("R9 status", v, 32'h0);
    rd(8'h00, v); check("R9 time", v, 32'h0);
    rd(8'h04, v); check("R9 date", v, 32'h0);
    rd(8'h10, v); check("R9 presc", v, 32'h007F00FF);
    rd(8'h18, v); check("R9 ctrl", v, 32'h0);
    check("R9 freeze", {31'h0, cal_freeze}, 32'h0);
    // R10 unmapped and key read
    rd(8'h08, v); check("R10 unmapped", v, 32'h0);
    rd(8'h24, v); check("R2 key reads zero", v, 32'h0);

    // R5 locked load ignored; R3 locked init ignored
    wr(8'h00, 32'h00123456);
    rd(8'h00, v); check("R5 locked time", v, m_time);
    wr(8'h0C, 32'h80);
    check_stat("R3 locked init");
    repeat (40) @(posedge clk);
    rd(8'h0C, v); check("R3 no freeze when locked", {31'h0, v[6]}, 32'h0);

    // R2 broken sequences
    wr(8'h24, 32'hCA); wr(8'h24, 32'h11); wr(8'h24, 32'h53);
    wr(8'h0C, 32'h80); check_stat("R2 wrong middle key");
    wr(8'h24, 32'h53);
    wr(8'h0C, 32'h80); check_stat("R2 lone second key");

    // R1 repeated first key still opens
    wr(8'h24, 32'hCA); wr(8'h24, 32'hCA); wr(8'h24, 32'h53);
    wr(8'h0C, 32'h80); check_stat("R1 unlock and request");
    rd(8'h24, v); check("R2 key reads zero open", v, 32'h0);
    poll(6, 1, 20, ok); check("R4 frozen sets", {31'h0, ok}, 32'h1);
    m_frozen = 1;
    check("R4 cal_freeze high", {31'h0, cal_freeze}, 32'h1);
    repeat (60) @(posedge clk);
    rd(8'h0C, v); check("R8 sync held clear frozen", {31'h0, v[5]}, 32'h0);

    // R6 masks, R7 loaded
    wr(8'h00, 32'hFFFFFFFF); rd(8'h00, v); check("R6 time mask", v, 32'h003F7F7F);
    wr(8'h04, 32'hFFFFFFFF); rd(8'h04, v); check("R6 date mask", v, 32'h00FFFF3F);
    check_stat("R7 loaded set");
    wr(8'h10, 32'hFFFFFFFF); rd(8'h10, v); check("R6 presc mask", v, 32'h007F7FFF);
    wr(8'h18, 32'hFFFFFFFF); rd(8'h18, v); check("R6 ctrl mask", v, 32'h000000FF);

    // R2 relock with 0xFF while frozen
    wr(8'h24, 32'hFF);
    wr(8'h00, 32'h00000012); rd(8'h00, v); check("R2 relocked load", v, 32'h003F7F7F);

    // R7 year zero clears loaded
    wr(8'h24, 32'hCA); wr(8'h24, 32'h53);
    wr(8'h04, 32'h00001231); check_stat("R7 loaded clear");
    wr(8'h00, 32'h00235959); rd(8'h00, v); check("R5 open frozen load", v, 32'h00235959);

    // R4 leave init
    wr(8'h0C, 32'h00);
    poll(6, 0, 20, ok); check("R4 frozen clears", {31'h0, ok}, 32'h1);
    m_frozen = 0;
    check("R4 cal_freeze low", {31'h0, cal_freeze}, 32'h0);
    wr(8'h00, 32'h00000001); rd(8'h00, v); check("R5 unfrozen load", v, 32'h00235959);

    // R8 sync flag
    poll(5, 1, 75, ok); check("R8 sync sets", {31'h0, ok}, 32'h1);
    wr(8'h24, 32'hFF);
    wr(8'h0C, 32'h00);
    rd(8'h0C, v); check("R8 clear while locked", {31'h0, v[5]}, 32'h0);
    check_stat("R3 request stays low");
    poll(5, 1, 75, ok); check("R8 sync sets again", {31'h0, ok}, 32'h1);

    cmp_on = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule